// File: doc/BRIEF.md
# I2C Master STOP Condition Generator with Collision Detection

This block produces the STOP condition at the end of an I2C transfer for a controller that can share the bus with other masters. On a request it first pulls SDA low while holding SCL low, then lets SCL go. It waits for the SCL line to actually read high, which gives a stretching slave or a competing master time to finish. It then keeps SCL high for one timed interval, lets SDA rise and checks the line once more after a final interval.

Each interval is timed by a down-counting baud timer that is reloaded from a 7-bit value. A reload of zero still gives a one-cycle interval. The line inputs are taken to be already synchronized to the clock. Both outputs are drive enables for open-drain pads: 1 pulls the line low and 0 lets it float high.

Two collision windows are watched. SCL reading low after it has been seen high but before SDA is let go is a collision. SDA reading low at the end of the final interval is also a collision. Either one aborts the sequence, lets go of both lines and sets a sticky collision flag. A normal finish sets a sticky done flag and pulses a completion interrupt for one cycle.

Top module: `i2c_stop_unit`

## Requirements
- R1: After reset, sda_oe, scl_oe, stop_done, done_irq and bus_coll are all 0.
- R2: A request (stop_req=1 while idle and bus_coll=0) sets sda_oe=1 and scl_oe=1 from the next cycle. SCL stays driven for L cycles, where L = reload when reload is nonzero and L = 1 when it is zero. SCL is then let go, but only at a clock edge where the timer has expired and sda_in reads 0. While sda_in reads 1, SCL stays driven.
- R3: Once SCL is let go, the block waits with sda_oe=1 for as long as scl_in reads 0. The edge at which scl_in first reads 1 starts an SCL-high interval of L cycles, with sda_oe still 1.
- R4: If scl_in reads 0 at any edge during the SCL-high interval, this is a collision. It also takes precedence over the expiry of that interval.
- R5: After the SCL-high interval, sda_oe=0 for L cycles. If sda_in reads 1 at the final edge, stop_done becomes 1 and done_irq is 1 for exactly one cycle. stop_done then stays 1 until the next request is accepted.
- R6: If sda_in reads 0 at the final edge of the SDA-high interval, this is a collision.
- R7: On a collision, bus_coll becomes 1 and sda_oe and scl_oe become 0 in the same cycle, and the block returns to idle. stop_done and done_irq stay 0.
- R8: bus_coll stays 1 until clr_coll=1 is sampled. Any stop_req sampled while bus_coll is 1 is ignored, including in the cycle where clr_coll is sampled.
- R9: A reload of 0 gives intervals of exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stop_req | input | 1 | Request a STOP condition |
| reload | input | 7 | Baud interval reload value |
| sda_in | input | 1 | Sampled SDA line level |
| scl_in | input | 1 | Sampled SCL line level |
| clr_coll | input | 1 | Clears the collision flag |
| sda_oe | output | 1 | 1 pulls SDA low |
| scl_oe | output | 1 | 1 pulls SCL low |
| stop_done | output | 1 | Sticky: the last STOP finished cleanly |
| done_irq | output | 1 | One-cycle pulse when a STOP finishes |
| bus_coll | output | 1 | Sticky bus-collision flag |

## Verification
The sequence is swept over several reload values, including zero and the largest value, and over several clock-stretch lengths. Counting the cycles each line is driven separates the baud period length from the added stretch time.

Two kinds of collision are injected. In the first, SCL is pulled low at every position of the SCL-high interval, which shows whether the abort point follows the injected cycle and whether a collision wins over the interval's expiry. In the second, SDA is held low through the final interval, which shows that the late sample is taken.

A further run keeps SDA reading high during setup to show that SCL is held until SDA reads low. The remaining runs check the sticky flags, the one-cycle interrupt and the blocking of requests while a collision is pending.

// File: rtl/i2c_stop_pkg.sv
package i2c_stop_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_WAIT_SCL,
    ST_SCL_HI,
    ST_SDA_HI
  } stop_st_e;

  // Number of cycles one baud interval lasts for a given reload value.
  function automatic int unsigned baud_cycles(input int unsigned rld);
    return (rld == 0) ? 1 : rld;
  endfunction

endpackage

// File: rtl/stop_baud_timer.sv
module stop_baud_timer #(
  parameter int RLD_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [RLD_W-1:0] reload,
  output logic             tick
);
  import i2c_stop_pkg::*;

  logic [RLD_W-1:0] cnt;
  int unsigned      len;

  assign len  = baud_cycles(int'(reload));
  assign tick = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= RLD_W'(len - 1);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  // R9: a zero reload expires right after loading
  a_r9_zero_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (load && reload == '0) |=> tick);

endmodule

// File: rtl/stop_sequencer.sv
module stop_sequencer
  import i2c_stop_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req,
  input  logic     blocked,
  input  logic     sda_in,
  input  logic     scl_in,
  input  logic     tick,
  output logic     load,
  output logic     accept,
  output logic     ev_done,
  output logic     ev_coll,
  output logic     sda_oe,
  output logic     scl_oe,
  output stop_st_e state
);

  stop_st_e nxt;
  logic     coll_scl_ev;
  logic     coll_sda_ev;

  always_comb begin
    nxt         = state;
    load        = 1'b0;
    accept      = 1'b0;
    ev_done     = 1'b0;
    coll_scl_ev = 1'b0;
    coll_sda_ev = 1'b0;
    case (state)
      ST_IDLE: if (req && !blocked) begin
        nxt    = ST_SETUP;
        load   = 1'b1;
        accept = 1'b1;
      end
      ST_SETUP: if (tick && !sda_in) nxt = ST_WAIT_SCL;
      ST_WAIT_SCL: if (scl_in) begin
        nxt  = ST_SCL_HI;
        load = 1'b1;
      end
      ST_SCL_HI: begin
        if (!scl_in) begin
          coll_scl_ev = 1'b1;
          nxt         = ST_IDLE;
        end else if (tick) begin
          nxt  = ST_SDA_HI;
          load = 1'b1;
        end
      end
      ST_SDA_HI: if (tick) begin
        nxt = ST_IDLE;
        if (!sda_in) coll_sda_ev = 1'b1;
        else         ev_done     = 1'b1;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  assign ev_coll = coll_scl_ev | coll_sda_ev;
  assign sda_oe  = (state == ST_SETUP) || (state == ST_WAIT_SCL) || (state == ST_SCL_HI);
  assign scl_oe  = (state == ST_SETUP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  // R2: SCL let go only after SDA read low
  a_r2_scl_after_sda: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_oe) |-> !$past(sda_in));

  // R3: SCL-high interval begins only once SCL was read high
  a_r3_wait_arbitration: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SCL_HI && $past(state) == ST_WAIT_SCL) |-> $past(scl_in));

  // R8: blocked requests leave the sequencer idle
  a_r8_blocked_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && blocked) |=> state == ST_IDLE);

endmodule

// File: rtl/stop_flags.sv
module stop_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_done,
  input  logic ev_coll,
  input  logic accept,
  input  logic clr_coll,
  output logic stop_done,
  output logic done_irq,
  output logic bus_coll
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_done <= 1'b0;
      done_irq  <= 1'b0;
      bus_coll  <= 1'b0;
    end else begin
      done_irq <= ev_done;
      if (ev_done)     stop_done <= 1'b1;
      else if (accept) stop_done <= 1'b0;
      if (ev_coll)       bus_coll <= 1'b1;
      else if (clr_coll) bus_coll <= 1'b0;
    end
  end

  // R5 / R7: completion never coexists with a collision
  a_r5_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> (stop_done && !bus_coll));

  // R5: interrupt lasts one cycle
  a_r5_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);

endmodule

// File: rtl/i2c_stop_unit.sv
module i2c_stop_unit #(
  parameter int RLD_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_req,
  input  logic [RLD_W-1:0] reload,
  input  logic             sda_in,
  input  logic             scl_in,
  input  logic             clr_coll,
  output logic             sda_oe,
  output logic             scl_oe,
  output logic             stop_done,
  output logic             done_irq,
  output logic             bus_coll
);
  import i2c_stop_pkg::*;

  logic     tick;
  logic     load;
  logic     accept;
  logic     ev_done;
  logic     ev_coll;
  stop_st_e state;

  stop_baud_timer #(.RLD_W(RLD_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load),
    .reload (reload),
    .tick   (tick)
  );

  stop_sequencer u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (stop_req),
    .blocked (bus_coll),
    .sda_in  (sda_in),
    .scl_in  (scl_in),
    .tick    (tick),
    .load    (load),
    .accept  (accept),
    .ev_done (ev_done),
    .ev_coll (ev_coll),
    .sda_oe  (sda_oe),
    .scl_oe  (scl_oe),
    .state   (state)
  );

  stop_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_done   (ev_done),
    .ev_coll   (ev_coll),
    .accept    (accept),
    .clr_coll  (clr_coll),
    .stop_done (stop_done),
    .done_irq  (done_irq),
    .bus_coll  (bus_coll)
  );

  // R7: a collision lets go of both lines at once
  a_r7_release_on_coll: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_coll) |-> (!sda_oe && !scl_oe && !stop_done));

  // R4 / R6: a new collision only arises from an active sequence
  a_r4_coll_from_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_coll) |-> $past(state == ST_SCL_HI || state == ST_SDA_HI));

endmodule

// File: tb/test_i2c_stop_unit.sv
module test_i2c_stop_unit;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stop_req = 1'b0;
  logic [6:0] reload = '0;
  logic       clr_coll = 1'b0;
  logic       ext_sda_low = 1'b0;
  logic       ext_scl_low = 1'b0;
  logic       force_sda_hi = 1'b0;
  logic       sda_oe, scl_oe, stop_done, done_irq, bus_coll;
  logic       sda_in, scl_in;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  // open-drain lines with pull-ups
  assign sda_in = force_sda_hi ? 1'b1 : !(sda_oe || ext_sda_low);
  assign scl_in = !(scl_oe || ext_scl_low);

  i2c_stop_unit i_i2c_stop_unit (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .reload(reload),
    .sda_in(sda_in), .scl_in(scl_in), .clr_coll(clr_coll),
    .sda_oe(sda_oe), .scl_oe(scl_oe), .stop_done(stop_done),
    .done_irq(done_irq), .bus_coll(bus_coll)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int period(input int rl);
    return (rl == 0) ? 1 : rl;
  endfunction

  // mode 0: clean, 1: SCL pulled low at SCL-high cycle j, 2: SDA held low, 3: SDA reads high during setup
  task automatic run_stop(input int rl, input int s, input int mode, input int j);
    int L, n_scl, n_sda, n_rel, q, it, x;
    int exp_scl, exp_sda, exp_rel;
    bit exp_coll;
    L = period(rl); n_scl = 0; n_sda = 0; n_rel = 0; q = 0;
    x = (mode == 3) ? 2 : 0;
    @(negedge clk);
    reload = rl[6:0]; stop_req = 1'b1;
    ext_sda_low = (mode == 2); force_sda_hi = (mode == 3);
    @(negedge clk);
    stop_req = 1'b0;
    check(stop_done == 1'b0, "R5 stop_done cleared on accept", int'(stop_done), 0);
    for (it = 0; it < 4000; it++) begin
      if (done_irq || bus_coll) break;
      n_scl += int'(scl_oe);
      n_sda += int'(sda_oe);
      n_rel += int'(!sda_oe && !scl_oe);
      force_sda_hi = (mode == 3) && (n_scl < L + x);
      if (!scl_oe && sda_oe) begin
        ext_scl_low = (q < s) || (mode == 1 && q >= s + 1 + j);
        q++;
      end else begin
        ext_scl_low = 1'b0;
      end
      @(negedge clk);
    end
    if (it >= 4000) check(1'b0, "R2 sequence hung", it, 0);
    exp_coll = (mode == 1) || (mode == 2);
    exp_scl  = L + x;
    exp_sda  = (mode == 1) ? (L + s + 1 + j + 1) : (2 * L + x + s + 1);
    exp_rel  = (mode == 1) ? 0 : L;
    check(n_scl == exp_scl, (rl == 0) ? "R9 SCL-low setup length" : "R2 SCL-low setup length", n_scl, exp_scl);
    check(n_sda == exp_sda, (mode == 1) ? "R4 abort point" : "R3 SDA-low length", n_sda, exp_sda);
    check(n_rel == exp_rel, "R5 SDA-high interval length", n_rel, exp_rel);
    check(bus_coll == exp_coll, (mode == 2) ? "R6 late SDA collision" : "R4 collision flag", int'(bus_coll), int'(exp_coll));
    check(stop_done == !exp_coll, "R7 stop_done outcome", int'(stop_done), int'(!exp_coll));
    check(done_irq == !exp_coll, "R5 done_irq outcome", int'(done_irq), int'(!exp_coll));
    check(!sda_oe && !scl_oe, "R7 lines released", int'({sda_oe, scl_oe}), 0);
    ext_scl_low = 1'b0; ext_sda_low = 1'b0; force_sda_hi = 1'b0;
    @(negedge clk);
    check(done_irq == 1'b0, "R5 done_irq one cycle", int'(done_irq), 0);
    check(bus_coll == exp_coll, "R8 bus_coll sticky", int'(bus_coll), int'(exp_coll));
    if (exp_coll) begin
      clr_coll = 1'b1;
      @(negedge clk);
      clr_coll = 1'b0;
      check(bus_coll == 1'b0, "R8 clr_coll clears", int'(bus_coll), 0);
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      check(1'b0, "watchdog expired", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int rls[7] = '{0, 1, 2, 3, 4, 7, 127};
    int sts[3] = '{0, 1, 3};
    repeat (3) @(negedge clk);
    check(!sda_oe && !scl_oe && !stop_done && !done_irq && !bus_coll, "R1 reset state",
          int'({sda_oe, scl_oe, stop_done, done_irq, bus_coll}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!sda_oe && !scl_oe && !bus_coll, "R1 idle after reset", int'({sda_oe, scl_oe, bus_coll}), 0);

    foreach (rls[a]) begin
      foreach (sts[b]) begin
        run_stop(rls[a], sts[b], 0, 0);
        run_stop(rls[a], sts[b], 2, 0);
        run_stop(rls[a], sts[b], 3, 0);
        if (period(rls[a]) <= 7) begin
          for (int jj = 0; jj < period(rls[a]); jj++) run_stop(rls[a], sts[b], 1, jj);
        end else begin
          run_stop(rls[a], sts[b], 1, 0);
          run_stop(rls[a], sts[b], 1, period(rls[a]) - 1);
        end
      end
    end

    // R8: requests ignored while the collision flag is set
    run_stop(2, 0, 2, 0);
    @(negedge clk);
    reload = 7'd2; ext_sda_low = 1'b1;
    @(negedge clk);
    ext_sda_low = 1'b0;
    // re-create a collision without clearing it afterwards
    stop_req = 1'b1; ext_sda_low = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    for (int k = 0; k < 40 && !bus_coll; k++) @(negedge clk);
    ext_sda_low = 1'b0;
    check(bus_coll == 1'b1, "R8 collision pending", int'(bus_coll), 1);
    stop_req = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(!sda_oe && !scl_oe, "R8 request ignored while flagged", int'({sda_oe, scl_oe}), 0);
    end
    clr_coll = 1'b1;
    @(negedge clk);
    clr_coll = 1'b0; stop_req = 1'b0;
    check(bus_coll == 1'b0, "R8 cleared", int'(bus_coll), 0);
    check(!sda_oe && !scl_oe, "R8 request in clear cycle ignored", int'({sda_oe, scl_oe}), 0);
    @(negedge clk);
    check(!sda_oe && !scl_oe, "R8 still idle", int'({sda_oe, scl_oe}), 0);
    run_stop(1, 1, 0, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule